// File: doc/BRIEF.md
# ADC Multiplexer Sequencer with Chopper

This block paces a six-input sampling front end from a 32768 Hz tick enable. Each multiplexer cycle begins on a tick, when the block latches its three settings: how many input slots to visit (2, 3, 4 or 6), whether conversions are short or long, and how the reference chopper should be poled. It then visits the slots in ascending order. For every slot it pulses a conversion start, waits the set number of ticks, and raises a write strobe while `slot_idx` names the storage location for the result. After the last slot it pulses a compute-start signal that launches the downstream compute pass, then waits for the next tick to open a new cycle.

The controller is a five-state machine. `S_SETUP` waits for a tick, latches the settings, resets the slot index and updates the chopper (transition `setup_go`). `S_ARM` pulses `conv_start` for one clock (transition `arm_to_conv`). `S_CONV` counts ticks and leaves on the final one (transition `conv_done`). `S_WRITE` pulses `wr_strobe`; it either advances the slot and returns to `S_ARM` (transition `next_slot`) or, on the last slot, moves to `S_KICK` (transition `last_slot`). `S_KICK` pulses `compute_start` and returns to `S_SETUP` (transition `kick_done`).

Top module: `adc_mux_sequencer`

## Requirements
- R1: While reset is low and in the first clock after it, `conv_start`, `wr_strobe` and `compute_start` are 0, `slot_idx` is 0 and `chop_pol` is 0 (normal).
- R2: `slot_sel` picks the slot count per cycle: 00 gives 2, 01 gives 3, 10 gives 4, 11 gives 6. Slots are visited as 0, 1, ... up to count-1 with exactly one `wr_strobe` per slot.
- R3: A conversion spans exactly 2 ticks after its `conv_start` when `fir_long` is 0 and exactly 3 ticks when it is 1. The tick that completes it is followed on the next clock by `wr_strobe`.
- R4: Each slot gets one one-clock `conv_start` before its `wr_strobe`, and `slot_idx` holds its value from that `conv_start` through the `wr_strobe`.
- R5: `res_wide` shows the `fir_long` value latched at the start of the current cycle (1 = 22-bit result, 0 = 21-bit result).
- R6: `chop_mode` 00 sets `chop_pol` to 0, 01 sets it to 1, and 10 or 11 inverts it, once per multiplexer cycle at the cycle start.
- R7: `chop_pol` changes only on the tick that opens a multiplexer cycle, never inside a cycle.
- R8: `compute_start` is a one-clock pulse issued on the clock after the last slot's `wr_strobe`, once per cycle.
- R9: Changes to `slot_sel`, `fir_long` and `chop_mode` made inside a cycle have no effect until the next cycle start.
- R10: The block advances only on ticks: while `tick` stays low, no conversion completes and no new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32768 Hz clock enable, one clock wide |
| slot_sel | input | 2 | Slot count per cycle (00=2, 01=3, 10=4, 11=6) |
| fir_long | input | 1 | Long conversion / wide result when 1 |
| chop_mode | input | 2 | Chopper mode (00 normal, 01 inverted, 1x toggle) |
| conv_start | output | 1 | One-clock pulse starting a conversion |
| wr_strobe | output | 1 | One-clock pulse storing the result at `slot_idx` |
| slot_idx | output | 3 | Current slot, the storage location for the result |
| res_wide | output | 1 | Latched result width selection for this cycle |
| chop_pol | output | 1 | Reference chopper polarity (0 normal, 1 inverted) |
| compute_start | output | 1 | One-clock pulse launching the compute pass |

## Verification
`conv_start` appears one clock after the tick that opens a cycle, or one clock after the previous `wr_strobe`; `wr_strobe` appears one clock after the tick that ends a conversion, and `compute_start` one clock after the last `wr_strobe`. The monitor samples two nanoseconds after each rising edge, so the tick it sees is the one the design consumed at that edge while in the previously observed state; it therefore ignores the tick consumed in the arm clock and counts the rest up to and including the strobe sample. Settings are changed only after a `compute_start` and at least two edges before the next opening tick, or deliberately mid-cycle to show they are ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SLOT_W = 3;

    typedef enum logic [2:0] {
        S_SETUP,
        S_ARM,
        S_CONV,
        S_WRITE,
        S_KICK
    } seq_state_e;

    // Index of the last slot for each selector code.
    function automatic logic [SLOT_W-1:0] last_slot_of(input logic [1:0] sel);
        logic [SLOT_W-1:0] r;
        unique case (sel)
            2'b00:   r = SLOT_W'(1);
            2'b01:   r = SLOT_W'(2);
            2'b10:   r = SLOT_W'(3);
            default: r = SLOT_W'(5);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_tick_timer.sv
module adc_seq_tick_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] len_m1,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = enable && tick && (cnt_q == len_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear || done) begin
            cnt_q <= '0;
        end else if (enable && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q <= len_m1)); // R3

endmodule

// File: rtl/adc_seq_chopper.sv
module adc_seq_chopper (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       update,
    input  logic [1:0] mode,
    output logic       pol
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol <= 1'b0;
        end else if (update) begin
            unique case (mode)
                2'b00:   pol <= 1'b0;
                2'b01:   pol <= 1'b1;
                default: pol <= ~pol;
            endcase
        end
    end

endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CONV_SHORT = 2,
    parameter int CONV_LONG  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        slot_sel,
    input  logic              fir_long,
    input  logic [1:0]        chop_mode,
    output logic              conv_start,
    output logic              wr_strobe,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              res_wide,
    output logic              chop_pol,
    output logic              compute_start
);

    localparam int CNT_W = (CONV_LONG > 2) ? $clog2(CONV_LONG) : 1;

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] last_q;
    logic              wide_q;
    logic [CNT_W-1:0]  len_m1_q;
    logic              conv_done;
    logic              cycle_open;

    assign cycle_open = (state_q == S_SETUP) && tick;

    adc_seq_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == S_ARM),
        .enable (state_q == S_CONV),
        .tick   (tick),
        .len_m1 (len_m1_q),
        .done   (conv_done)
    );

    adc_seq_chopper u_chop (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (cycle_open),
        .mode   (chop_mode),
        .pol    (chop_pol)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_SETUP;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SETUP: if (tick) state_d = S_ARM;                          // setup_go
            S_ARM:   state_d = S_CONV;                                   // arm_to_conv
            S_CONV:  if (conv_done) state_d = S_WRITE;                   // conv_done
            S_WRITE: state_d = (slot_q == last_q) ? S_KICK : S_ARM;      // last_slot / next_slot
            S_KICK:  state_d = S_SETUP;                                  // kick_done
            default: state_d = S_SETUP;
        endcase
    end

    // Cycle settings and slot index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '0;
            last_q   <= SLOT_W'(1);
            wide_q   <= 1'b0;
            len_m1_q <= CNT_W'(CONV_SHORT - 1);
        end else if (cycle_open) begin
            slot_q   <= '0;
            last_q   <= last_slot_of(slot_sel);
            wide_q   <= fir_long;
            len_m1_q <= fir_long ? CNT_W'(CONV_LONG - 1) : CNT_W'(CONV_SHORT - 1);
        end else if (state_q == S_WRITE && slot_q != last_q) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        conv_start    = (state_q == S_ARM);
        wr_strobe     = (state_q == S_WRITE);
        compute_start = (state_q == S_KICK);
        slot_idx      = slot_q;
        res_wide      = wide_q;
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= last_q); // R2

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $stable(slot_idx)); // R4

    AST_KICK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        compute_start |-> $past(wr_strobe)); // R8

    AST_KICK_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        compute_start |-> (slot_idx == last_q)); // R8

    AST_POL_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_SETUP) |=> $stable(chop_pol)); // R7

    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_SETUP) |=> ($stable(last_q) && $stable(res_wide))); // R9

    AST_WAIT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SETUP && !tick) |=> (state_q == S_SETUP)); // R10

endmodule

// File: tb/adc_mux_sequencer_bench.sv
module adc_mux_sequencer_bench;

    typedef struct packed {
        logic       kick;
        logic [2:0] slot;
        logic       wide;
        logic [1:0] len;
        logic       pol;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] div = 2'd0;
    logic [1:0] slot_sel = 2'b00;
    logic       fir_long = 1'b0;
    logic [1:0] chop_mode = 2'b00;
    logic       conv_start, wr_strobe, res_wide, chop_pol, compute_start;
    logic [2:0] slot_idx;

    int   total = 0;
    int   bad = 0;
    int   events = 0;
    exp_t q[$];
    logic pol_m = 1'b0;
    int   tcnt = 0;
    logic skip = 1'b0;

    always #4 clk = ~clk;

    adc_mux_sequencer u_adc_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slot_sel(slot_sel),
        .fir_long(fir_long), .chop_mode(chop_mode), .conv_start(conv_start),
        .wr_strobe(wr_strobe), .slot_idx(slot_idx), .res_wide(res_wide),
        .chop_pol(chop_pol), .compute_start(compute_start)
    );

    // Tick generator: one clock high every four clocks.
    always @(negedge clk) begin
        div  <= div + 2'd1;
        tick <= tick_en && (div == 2'd3);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (conv_start) begin
                tcnt = 0;
                skip = 1'b1;
            end else if (skip) begin
                skip = 1'b0;
            end else if (tick) begin
                tcnt++;
            end
            if (wr_strobe || compute_start) begin
                events++;
                if (q.size() == 0) begin
                    check(0, "R2 unexpected event", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (wr_strobe) begin
                        check(!e.kick, "R8 strobe order", 1, int'(e.kick));
                        check(slot_idx == e.slot, "R2 slot", slot_idx, e.slot);
                        check(tcnt == int'(e.len), "R3 ticks", tcnt, e.len);
                        check(res_wide == e.wide, "R5 width", res_wide, e.wide);
                    end else begin
                        check(e.kick, "R8 kick order", 0, 1);
                        check(chop_pol == e.pol, "R6 polarity", chop_pol, e.pol);
                    end
                end
            end
        end
    end

    task automatic run_cycle(input logic [1:0] sel, input logic fir,
                             input logic [1:0] chop, input bit glitch, input bit pause);
        int n;
        exp_t e;
        slot_sel  = sel;
        fir_long  = fir;
        chop_mode = chop;
        n = (sel == 2'b00) ? 2 : (sel == 2'b01) ? 3 : (sel == 2'b10) ? 4 : 6;
        pol_m = (chop == 2'b00) ? 1'b0 : (chop == 2'b01) ? 1'b1 : ~pol_m;
        for (int s = 0; s < n; s++) begin
            e = '{kick: 1'b0, slot: 3'(s), wide: fir, len: fir ? 2'd3 : 2'd2, pol: 1'b0};
            q.push_back(e);
        end
        e = '{kick: 1'b1, slot: 3'd0, wide: 1'b0, len: 2'd0, pol: pol_m};
        q.push_back(e);
        if (glitch || pause) begin
            wait (q.size() == n);
            if (glitch) begin
                // R9: mid-cycle changes must be ignored
                slot_sel  = ~sel;
                fir_long  = ~fir;
                chop_mode = (chop == 2'b01) ? 2'b00 : 2'b01;
            end
            if (pause) begin
                int ev0;
                ev0 = events;
                tick_en = 1'b0;
                repeat (40) @(posedge clk);
                check(events == ev0, "R10 no progress without tick", events - ev0, 0);
                tick_en = 1'b1;
            end
        end
        wait (q.size() == 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #2;
                check(!conv_start && !wr_strobe && !compute_start, "R1 strobes in reset",
                      int'(conv_start | wr_strobe | compute_start), 0);
                check(slot_idx == 3'd0 && !chop_pol, "R1 slot and polarity",
                      int'(slot_idx) + int'(chop_pol), 0);
                @(negedge clk);
                rst_n = 1'b1;
                @(posedge clk);
                #2;
                check(!wr_strobe && !compute_start && slot_idx == 3'd0 && !chop_pol,
                      "R1 after reset", int'(slot_idx), 0);
                run_cycle(2'b00, 1'b0, 2'b00, 0, 0);
                run_cycle(2'b01, 1'b1, 2'b01, 0, 0);
                run_cycle(2'b10, 1'b0, 2'b10, 0, 0);
                run_cycle(2'b11, 1'b1, 2'b11, 0, 0);
                run_cycle(2'b11, 1'b0, 2'b10, 0, 0);
                run_cycle(2'b01, 1'b0, 2'b00, 1, 0);
                run_cycle(2'b10, 1'b1, 2'b11, 0, 1);
                run_cycle(2'b00, 1'b1, 2'b01, 1, 0);
                run_cycle(2'b00, 1'b0, 2'b10, 0, 0);
                run_cycle(2'b11, 1'b0, 2'b11, 0, 0);
                repeat (4) @(posedge clk);
                check(q.size() == 0, "R8 queue drained", q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule